// File: doc/BRIEF.md
# Bus Peripheral Address Recognizer

This block sits on the bus interface of a peripheral. It watches a 15-bit bus address whose lines are active-low and decides whether the current bus cycle is aimed at this peripheral. The address is first inverted to active-high. Bits 4 to 11 are then compared for equality with an 8-bit device number set on jumper inputs. Bits 12 to 15 must all be high. When both conditions hold while the bus strobe is asserted, a registered match flag is set. The flag stays set until the strobe drops or reset is asserted.

The three lowest address bits are decoded into three register selects: control, status and data. Each select can assert only while the match flag is set. The control and status selects are active-low, and the data select is active-high. This lets the selects drive downstream register logic directly. While the peripheral requests bus access, the block also places the jumper device number on data bits 11:4 so that the bus master can identify the requester.

Top module: `bus_addr_recog`

## Requirements
- R1: The cycle after a clock edge that samples `bus_strobe` high and a recognized address, `match` reads 1. An address is recognized when the inverted `addr_n[11:4]` equals `dev_jmp` and the inverted `addr_n[15:12]` is all ones.
- R2: If any single bit of the inverted `addr_n[11:4]` differs from `dev_jmp`, `match` stays 0.
- R3: If any of the inverted address bits 15, 14, 13 or 12 is 0, `match` stays 0.
- R4: After an edge that samples `bus_strobe` low, `match` is 0. Asserting `rst_n` low clears `match` at once, even in the middle of a cycle.
- R5: `ctrl_sel_n` is 0 exactly when `match` is 1 and inverted bits {3,2,1} are 3'b011 (bits 1 and 2 high, bit 3 low). Otherwise it is 1.
- R6: `stat_sel_n` is 0 exactly when `match` is 1 and inverted bits {3,2,1} are 3'b000. Otherwise it is 1.
- R7: `data_sel` is 1 exactly when `match` is 1 and inverted bits {3,2,1} are 3'b100 (bit 3 high, bits 1 and 2 low). Otherwise it is 0.
- R8: The other five low-bit patterns assert no select, and at most one select is active at any time.
- R9: While `acc_req` is 1, `dev_data[11:4]` equals `dev_jmp`, all other `dev_data` bits are 0, and `dev_data_en` is 1. While `acc_req` is 0, `dev_data` is all zeros and `dev_data_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_strobe | input | 1 | High for the duration of a bus cycle |
| addr_n | input | 15 | Bus address bits 15..1, active-low |
| dev_jmp | input | 8 | Device number from the jumpers |
| acc_req | input | 1 | Peripheral is requesting bus access |
| match | output | 1 | Registered address-match flag |
| ctrl_sel_n | output | 1 | Control register select, active-low |
| stat_sel_n | output | 1 | Status register select, active-low |
| data_sel | output | 1 | Data register select, active-high |
| dev_data | output | 16 | Device number placed on data bits 11:4 |
| dev_data_en | output | 1 | Marks `dev_data` as driven |

## Verification
Some rules are checked by assertions on every clock cycle:
- the match flag rises only after a strobed recognized address;
- the flag always clears after the strobe falls;
- no more than one select is active at once;
- no select is active without the flag.

The bench scenarios cover what the assertions cannot. They confirm that every one of the eight low-bit patterns maps to the right select with the right polarity. They also walk a single wrong bit through each device-number position and each upper address bit, apply reset in the middle of a cycle, and check where the jumper value lands on the data lines.

// File: rtl/bar_pkg.sv
package bar_pkg;
   // Number of low address bits that pick a register, and number of selects
   localparam int SEL_W   = 3;
   localparam int NUM_SEL = 3;
   // Select indices
   localparam int SEL_CTRL = 0;
   localparam int SEL_STAT = 1;
   localparam int SEL_DATA = 2;
   // Codes for bits {3,2,1}, packed with index 0 in the least significant slice
   localparam logic [NUM_SEL*SEL_W-1:0] SEL_CODES = {3'b100, 3'b000, 3'b011};
   // Output polarity per select: 1 = active-high
   localparam logic [NUM_SEL-1:0] SEL_POL = 3'b100;
endpackage

// File: rtl/bar_addr_match.sv
module bar_addr_match #(
   parameter int ADDR_W     = 15,
   parameter int DEV_LO     = 4,
   parameter int DEV_W      = 8,
   parameter bit HOLD_MATCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic [ADDR_W:1]   addr,
   input  logic [DEV_W-1:0]  dev_num,
   output logic              match
);
   localparam int UP_LO = DEV_LO + DEV_W;

   initial begin
      geom_ok_chk: assert (UP_LO <= ADDR_W && DEV_LO >= 2)
         else $error("address fields do not fit");
   end

   logic dev_eq, upper_ok, hit, match_d;

   assign dev_eq   = (addr[UP_LO-1:DEV_LO] == dev_num);
   assign upper_ok = &addr[ADDR_W:UP_LO];
   assign hit      = dev_eq & upper_ok;

   generate
      if (HOLD_MATCH) begin : g_hold
         assign match_d = strobe & (match | hit);
      end else begin : g_track
         assign match_d = strobe & hit;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match <= 1'b0;
      else        match <= match_d;
   end

   // R1
   match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && hit) |=> match);
   // R4
   match_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> !match);
endmodule

// File: rtl/bar_sel_decode.sv
module bar_sel_decode
   import bar_pkg::*;
(
   input  logic             match,
   input  logic [SEL_W:1]   low_bits,
   output logic [NUM_SEL-1:0] sel_out
);
   initial begin
      codes_unique_chk: assert (SEL_CODES[0 +: SEL_W] != SEL_CODES[SEL_W +: SEL_W]
                             && SEL_CODES[0 +: SEL_W] != SEL_CODES[2*SEL_W +: SEL_W]
                             && SEL_CODES[SEL_W +: SEL_W] != SEL_CODES[2*SEL_W +: SEL_W])
         else $error("select codes overlap");
   end

   generate
      for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
         logic hit_i;
         assign hit_i = match & (low_bits == SEL_CODES[i*SEL_W +: SEL_W]);
         if (SEL_POL[i]) begin : g_hi
            assign sel_out[i] = hit_i;
         end else begin : g_lo
            assign sel_out[i] = ~hit_i;
         end
      end
   endgenerate
endmodule

// File: rtl/bar_devnum_drive.sv
module bar_devnum_drive #(
   parameter int DATA_W = 16,
   parameter int DEV_LO = 4,
   parameter int DEV_W  = 8
) (
   input  logic              acc_req,
   input  logic [DEV_W-1:0]  dev_num,
   output logic [DATA_W-1:0] data,
   output logic              data_en
);
   initial begin
      width_ok_chk: assert (DEV_LO + DEV_W <= DATA_W)
         else $error("device number does not fit the data bus");
   end

   logic [DATA_W-1:0] placed;
   assign placed  = DATA_W'(dev_num) << DEV_LO;
   assign data    = acc_req ? placed : '0;
   assign data_en = acc_req;
endmodule

// File: rtl/bus_addr_recog.sv
module bus_addr_recog
   import bar_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DEV_W  = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_strobe,
   input  logic [ADDR_W:1]   addr_n,
   input  logic [DEV_W-1:0]  dev_jmp,
   input  logic              acc_req,
   output logic              match,
   output logic              ctrl_sel_n,
   output logic              stat_sel_n,
   output logic              data_sel,
   output logic [DATA_W-1:0] dev_data,
   output logic              dev_data_en
);
   localparam int DEV_LO = SEL_W + 1;

   logic [ADDR_W:1]    addr_hi;
   logic [NUM_SEL-1:0] sel_vec;

   assign addr_hi = ~addr_n;

   bar_addr_match #(
      .ADDR_W(ADDR_W), .DEV_LO(DEV_LO), .DEV_W(DEV_W), .HOLD_MATCH(1'b1)
   ) match_i (
      .clk(clk), .rst_n(rst_n), .strobe(bus_strobe),
      .addr(addr_hi), .dev_num(dev_jmp), .match(match)
   );

   bar_sel_decode dec_i (
      .match(match), .low_bits(addr_hi[SEL_W:1]), .sel_out(sel_vec)
   );

   assign ctrl_sel_n = sel_vec[SEL_CTRL];
   assign stat_sel_n = sel_vec[SEL_STAT];
   assign data_sel   = sel_vec[SEL_DATA];

   bar_devnum_drive #(
      .DATA_W(DATA_W), .DEV_LO(DEV_LO), .DEV_W(DEV_W)
   ) drv_i (
      .acc_req(acc_req), .dev_num(dev_jmp), .data(dev_data), .data_en(dev_data_en)
   );

   // R8
   one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~ctrl_sel_n, ~stat_sel_n, data_sel}) <= 1);
   // R5
   sel_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_sel_n || !stat_sel_n || data_sel) |-> match);
   // R1
   match_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match) |-> $past(bus_strobe));
endmodule

// File: tb/bus_addr_recog_tb_top.sv
module bus_addr_recog_tb_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_strobe = 1'b0;
   logic [15:1] addr_n = '1;
   logic [7:0]  dev_jmp = 8'hA5;
   logic        acc_req = 1'b0;
   logic        match, ctrl_sel_n, stat_sel_n, data_sel, dev_data_en;
   logic [15:0] dev_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   bus_addr_recog dut_i (
      .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .addr_n(addr_n),
      .dev_jmp(dev_jmp), .acc_req(acc_req), .match(match),
      .ctrl_sel_n(ctrl_sel_n), .stat_sel_n(stat_sel_n), .data_sel(data_sel),
      .dev_data(dev_data), .dev_data_en(dev_data_en)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:1] mk_addr(input logic [7:0] dev,
                                           input logic [2:0] low,
                                           input logic [3:0] up);
      return {up, dev, low};
   endfunction

   // Runs one strobed cycle with an active-high address; checks match and selects
   task automatic bus_cycle(input logic [15:1] a, input bit exp_hit, input string req);
      logic [2:0] lo;
      lo = a[3:1];
      @(negedge clk);
      addr_n = ~a;
      bus_strobe = 1'b1;
      @(posedge clk); #2;
      chk(match == exp_hit, req, match, exp_hit);
      chk(ctrl_sel_n == !(exp_hit && lo == 3'b011), "R5", ctrl_sel_n, !(exp_hit && lo == 3'b011));
      chk(stat_sel_n == !(exp_hit && lo == 3'b000), "R6", stat_sel_n, !(exp_hit && lo == 3'b000));
      chk(data_sel == (exp_hit && lo == 3'b100), "R7", data_sel, (exp_hit && lo == 3'b100));
      @(negedge clk);
      bus_strobe = 1'b0;
      @(posedge clk); #2;
      chk(match == 1'b0, "R4", match, 0);
   endtask

   task automatic t_reset();
      #3;
      chk(match == 1'b0, "R4", match, 0);
      chk({ctrl_sel_n, stat_sel_n, data_sel} == 3'b110, "R8", {ctrl_sel_n, stat_sel_n, data_sel}, 3'b110);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_low_patterns();
      for (int p = 0; p < 8; p++) begin
         bus_cycle(mk_addr(dev_jmp, 3'(p), 4'hF), 1'b1, "R1");
         if (!(p == 3 || p == 0 || p == 4))
            chk({ctrl_sel_n, stat_sel_n, data_sel} == 3'b110, "R8",
                {ctrl_sel_n, stat_sel_n, data_sel}, 3'b110);
      end
   endtask

   task automatic t_dev_mismatch();
      for (int b = 0; b < 8; b++)
         bus_cycle(mk_addr(dev_jmp ^ (8'h1 << b), 3'b011, 4'hF), 1'b0, "R2");
   endtask

   task automatic t_upper_bits();
      for (int b = 0; b < 4; b++)
         bus_cycle(mk_addr(dev_jmp, 3'b000, 4'hF ^ (4'h1 << b)), 1'b0, "R3");
   endtask

   task automatic t_other_jumper();
      dev_jmp = 8'h3C;
      bus_cycle(mk_addr(8'h3C, 3'b100, 4'hF), 1'b1, "R1");
      bus_cycle(mk_addr(8'hA5, 3'b100, 4'hF), 1'b0, "R2");
   endtask

   task automatic t_mid_reset();
      @(negedge clk);
      addr_n = ~mk_addr(dev_jmp, 3'b100, 4'hF);
      bus_strobe = 1'b1;
      @(posedge clk); #2;
      chk(match == 1'b1, "R1", match, 1);
      rst_n = 1'b0;
      #1;
      chk(match == 1'b0, "R4", match, 0);
      chk(data_sel == 1'b0, "R7", data_sel, 0);
      @(negedge clk);
      bus_strobe = 1'b0;
      rst_n = 1'b1;
   endtask

   task automatic t_devnum();
      acc_req = 1'b0;
      #1;
      chk(dev_data == 16'h0 && !dev_data_en, "R9", {dev_data_en, dev_data}, 0);
      dev_jmp = 8'h81;
      acc_req = 1'b1;
      #1;
      chk(dev_data == 16'h0810 && dev_data_en, "R9", {dev_data_en, dev_data}, 17'h10810);
      dev_jmp = 8'h5E;
      #1;
      chk(dev_data == 16'h05E0, "R9", dev_data, 16'h05E0);
      acc_req = 1'b0;
      #1;
      chk(dev_data == 16'h0 && !dev_data_en, "R9", {dev_data_en, dev_data}, 0);
   endtask

   initial begin
      t_reset();
      t_low_patterns();
      t_dev_mismatch();
      t_upper_bits();
      t_other_jumper();
      t_mid_reset();
      t_devnum();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule